// File: doc/BRIEF.md
# Per-Chip DRAM Refresh Scheduler

This block decides when each DRAM chip in a small array gets refreshed. Every chip owns a refresh period timer that stays parked until the first access to that chip arrives. Because chips see their first access at different times, their refreshes are naturally staggered. When a chip's timer expires, the block looks at the busy flags of all banks in that chip. If any bank is busy, it does not force the refresh. It records that a refresh is owed and starts it on the first cycle in which the whole chip is idle.

A refresh holds the chip's refresh-active output for a fixed number of cycles. At completion, the block pulses a row-invalidate line for every bank of the chip, so that the neighbouring bank logic forgets its open rows. In the same cycle it grants the lowest-numbered bank of that chip that has a queued access waiting. It then re-arms the period timer from the completion point.

Banks are numbered globally and interleaved across chips: bank b of chip c has global index c + N_CHIPS*b. A sticky error output reports a refresh that was missed: a second expiry of the period while an earlier refresh was still owed.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, refresh_active, refresh_needed, row_invalidate, bank_grant and overrun_err are all zero. No chip ever refreshes unless a first-access strobe has been seen for it.
- R2: The first first_access strobe for a chip, sampled at a clock edge k, arms that chip's timer. The refresh falls due at edge k+REF_PERIOD. Any further strobes to an armed chip are ignored.
- R3: If a refresh falls due while any bank of the chip reports busy, the chip's refresh_needed goes to 1 at that edge and refresh_active stays 0. Busy banks belonging to other chips have no effect on this decision.
- R4: If a refresh falls due while all banks of the chip are idle, refresh_active goes to 1 at that edge and refresh_needed is 0. refresh_active stays high for exactly REF_DELAY cycles.
- R5: An owed refresh starts at the first edge at which no bank of the chip is busy. At that edge refresh_active goes high and refresh_needed goes low.
- R6: At the edge where refresh_active falls, row_invalidate goes high for exactly one cycle on every bank of that chip, at global index c + N_CHIPS*b, and on no other bank.
- R7: In that same cycle, bank_grant is a one-cycle pulse on the single lowest-b bank of the chip whose bank_pending bit is set. If no bank of the chip is pending, bank_grant stays zero.
- R8: The next refresh falls due REF_PERIOD edges after the completion edge, not after the previous due point.
- R9: While a refresh is owed, the period timer keeps running from the deferral point. If it expires again before the refresh has started, overrun_err goes to 1. It stays at 1 until reset, including after the refresh is done.
- R10: The chips are independent. Chips armed at different edges refresh at correspondingly different edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| first_access | input | N_CHIPS | One-cycle strobe per chip that marks the first access to it |
| bank_busy | input | N_CHIPS*BANKS_PER_CHIP | Per-bank busy flag, global index c + N_CHIPS*b |
| bank_pending | input | N_CHIPS*BANKS_PER_CHIP | Per-bank queue-not-empty flag, same indexing |
| refresh_active | output | N_CHIPS | Chip is in a refresh |
| refresh_needed | output | N_CHIPS | Refresh is owed but deferred by a busy bank |
| row_invalidate | output | N_CHIPS*BANKS_PER_CHIP | One-cycle pulse that clears a bank's open-row state |
| bank_grant | output | N_CHIPS*BANKS_PER_CHIP | One-cycle pulse that releases one queued bank access |
| overrun_err | output | 1 | Sticky missed-refresh flag |

## Verification
The assertions assume that the bank logic stops marking banks of a chip busy while that chip refreshes. They also assume that busy and pending are settled levels sampled at the clock edge, not glitches. The stimulus only changes these flags between edges and never raises a bank's busy flag while its chip is refreshing. The strobes are single-cycle pulses, so each armed timer sees one clean start.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic [1:0] {
        CH_OFF     = 2'd0,
        CH_COUNT   = 2'd1,
        CH_DEFER   = 2'd2,
        CH_REFRESH = 2'd3
    } chip_state_e;

    typedef struct packed {
        logic active;
        logic needed;
        logic overrun;
    } chip_status_t;

    // Interleaved global bank numbering across chips.
    function automatic int gbank(input int chip, input int bank, input int nchips);
        return chip + nchips * bank;
    endfunction

endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
    parameter int MAXV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic zero
);
    localparam int CW = (MAXV < 2) ? 1 : $clog2(MAXV);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(MAXV - 1);
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/refsched_pick.sv
module refsched_pick #(
    parameter int W = 4
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] grant
);
    always_comb begin
        grant = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) grant = '0;
            if (req[i]) grant[i] = 1'b1;
        end
    end
endmodule

// File: rtl/refsched_chip.sv
module refsched_chip
    import refsched_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int PERIOD = 20,
    parameter int DELAY  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [BANKS-1:0] busy,
    input  logic [BANKS-1:0] pending,
    output chip_status_t     status,
    output logic [BANKS-1:0] inval,
    output logic [BANKS-1:0] grant
);
    chip_state_e      state_q, state_d;
    logic             needed_q, needed_d;
    logic             err_q, err_d;
    logic [BANKS-1:0] inval_q, grant_q, pick;
    logic             p_load, d_load, p_zero, d_zero, p_run, finish;
    logic             busy_any, p_due, d_done, active;

    assign busy_any = |busy;
    assign active   = (state_q == CH_REFRESH);
    assign p_run    = (state_q == CH_COUNT) || (state_q == CH_DEFER);
    assign p_due    = p_run && p_zero;
    assign d_done   = active && d_zero;

    refsched_timer #(.MAXV(PERIOD)) u_period (
        .clk(clk), .rst(rst), .load(p_load), .run(p_run), .zero(p_zero)
    );

    refsched_timer #(.MAXV(DELAY)) u_delay (
        .clk(clk), .rst(rst), .load(d_load), .run(active), .zero(d_zero)
    );

    refsched_pick #(.W(BANKS)) u_pick (.req(pending), .grant(pick));

    always_comb begin
        state_d  = state_q;
        needed_d = needed_q;
        err_d    = err_q;
        p_load   = 1'b0;
        d_load   = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            CH_OFF: begin
                if (start) begin
                    state_d = CH_COUNT;
                    p_load  = 1'b1;
                end
            end
            CH_COUNT: begin
                if (p_due) begin
                    if (busy_any) begin
                        state_d  = CH_DEFER;
                        needed_d = 1'b1;
                        p_load   = 1'b1;
                    end else begin
                        state_d = CH_REFRESH;
                        d_load  = 1'b1;
                    end
                end
            end
            CH_DEFER: begin
                if (!busy_any) begin
                    state_d  = CH_REFRESH;
                    needed_d = 1'b0;
                    d_load   = 1'b1;
                end else if (p_due) begin
                    err_d  = 1'b1;
                    p_load = 1'b1;
                end
            end
            CH_REFRESH: begin
                if (d_done) begin
                    state_d = CH_COUNT;
                    p_load  = 1'b1;
                    finish  = 1'b1;
                end
            end
            default: state_d = CH_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= CH_OFF;
            needed_q <= 1'b0;
            err_q    <= 1'b0;
            inval_q  <= '0;
            grant_q  <= '0;
        end else begin
            state_q  <= state_d;
            needed_q <= needed_d;
            err_q    <= err_d;
            inval_q  <= finish ? '1 : '0;
            grant_q  <= finish ? pick : '0;
        end
    end

    assign status = '{active: active, needed: needed_q, overrun: err_q};
    assign inval  = inval_q;
    assign grant  = grant_q;

    // R4 / R5: a refresh only begins when the chip was idle.
    a_r4_start_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(!busy_any));

    // R3: an owed refresh and an active refresh never coexist.
    a_r3_needed_excl: assert property (@(posedge clk) disable iff (rst)
        !(needed_q && active));

    // R6: invalidation follows the end of a refresh and covers every bank.
    a_r6_inval_on_end: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> (&inval_q));

    // R7: at most one grant, and only to a bank that was pending.
    a_r7_grant_single: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_q));

    a_r7_grant_pending: assert property (@(posedge clk) disable iff (rst)
        (|grant_q) |-> ((grant_q & $past(pending)) == grant_q));

    // R9: the overrun flag never clears outside reset.
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(err_q) |-> err_q);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import refsched_pkg::*;
#(
    parameter int N_CHIPS        = 2,
    parameter int BANKS_PER_CHIP = 4,
    parameter int REF_PERIOD     = 20,
    parameter int REF_DELAY      = 5,
    localparam int NB            = N_CHIPS * BANKS_PER_CHIP
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_CHIPS-1:0] first_access,
    input  logic [NB-1:0]      bank_busy,
    input  logic [NB-1:0]      bank_pending,
    output logic [N_CHIPS-1:0] refresh_active,
    output logic [N_CHIPS-1:0] refresh_needed,
    output logic [NB-1:0]      row_invalidate,
    output logic [NB-1:0]      bank_grant,
    output logic               overrun_err
);
    logic [N_CHIPS-1:0] err_v;

    for (genvar c = 0; c < N_CHIPS; c++) begin : g_chip
        logic [BANKS_PER_CHIP-1:0] busy_c, pend_c, inval_c, grant_c;
        chip_status_t              st_c;

        for (genvar b = 0; b < BANKS_PER_CHIP; b++) begin : g_bank
            localparam int GI = gbank(c, b, N_CHIPS);
            assign busy_c[b]          = bank_busy[GI];
            assign pend_c[b]          = bank_pending[GI];
            assign row_invalidate[GI] = inval_c[b];
            assign bank_grant[GI]     = grant_c[b];
        end

        refsched_chip #(
            .BANKS (BANKS_PER_CHIP),
            .PERIOD(REF_PERIOD),
            .DELAY (REF_DELAY)
        ) u_chip (
            .clk    (clk),
            .rst    (rst),
            .start  (first_access[c]),
            .busy   (busy_c),
            .pending(pend_c),
            .status (st_c),
            .inval  (inval_c),
            .grant  (grant_c)
        );

        assign refresh_active[c] = st_c.active;
        assign refresh_needed[c] = st_c.needed;
        assign err_v[c]          = st_c.overrun;
    end

    assign overrun_err = |err_v;

endmodule

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 2;
    localparam int BPC = 4;
    localparam int P = 20;
    localparam int D = 5;
    localparam int NB = NC * BPC;

    logic          clk = 1'b0;
    logic          rst;
    logic [NC-1:0] first_access;
    logic [NB-1:0] bank_busy, bank_pending;
    logic [NC-1:0] refresh_active, refresh_needed;
    logic [NB-1:0] row_invalidate, bank_grant;
    logic          overrun_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dram_refresh_sched #(
        .N_CHIPS(NC), .BANKS_PER_CHIP(BPC), .REF_PERIOD(P), .REF_DELAY(D)
    ) u_dut (
        .clk(clk), .rst(rst), .first_access(first_access),
        .bank_busy(bank_busy), .bank_pending(bank_pending),
        .refresh_active(refresh_active), .refresh_needed(refresh_needed),
        .row_invalidate(row_invalidate), .bank_grant(bank_grant),
        .overrun_err(overrun_err)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        first_access = '0;
        bank_busy = '0;
        bank_pending = '0;
        step(3);
        rst = 1'b0;
    endtask

    task automatic strobe(input logic [NC-1:0] which);
        first_access = which;
        step(1);
        first_access = '0;
    endtask

    // R1: quiet after reset, and nothing happens without a first access
    task automatic t_reset();
        do_reset();
        chk("R1", "active", refresh_active, 0);
        chk("R1", "needed", refresh_needed, 0);
        chk("R1", "inval", row_invalidate, 0);
        chk("R1", "grant", bank_grant, 0);
        chk("R1", "err", overrun_err, 0);
        step(3 * P);
        chk("R1", "active unstarted", refresh_active, 0);
    endtask

    // R2 R4 R6 R7 R8 on chip 0
    task automatic t_basic();
        do_reset();
        bank_pending = 8'b0101_0010;
        strobe(2'b01);
        step(5);
        strobe(2'b01);
        step(P - 7);
        chk("R2", "active before due", refresh_active, 2'b00);
        step(1);
        chk("R2", "active at due", refresh_active, 2'b01);
        chk("R4", "needed clear", refresh_needed, 2'b00);
        step(D - 1);
        chk("R4", "active last cycle", refresh_active, 2'b01);
        chk("R6", "no early inval", row_invalidate, 0);
        step(1);
        chk("R4", "active ended", refresh_active, 2'b00);
        chk("R6", "inval chip0", row_invalidate, 8'b0101_0101);
        chk("R7", "grant lowest pending", bank_grant, 8'b0001_0000);
        step(1);
        chk("R6", "inval one cycle", row_invalidate, 0);
        chk("R7", "grant one cycle", bank_grant, 0);
        step(P - 2);
        chk("R8", "before next due", refresh_active, 2'b00);
        step(1);
        chk("R8", "next due", refresh_active, 2'b01);
    endtask

    // R3 R5 R7 on chip 1
    task automatic t_defer();
        do_reset();
        strobe(2'b10);
        bank_busy = 8'b0000_1000;
        step(P - 1);
        chk("R3", "needed before due", refresh_needed, 2'b00);
        step(1);
        chk("R3", "needed set", refresh_needed, 2'b10);
        chk("R3", "not active", refresh_active, 2'b00);
        bank_busy = 8'b0000_1100;
        step(3);
        chk("R3", "still deferred", refresh_active, 2'b00);
        bank_busy = 8'b0000_0100;
        step(1);
        chk("R5", "started when idle", refresh_active, 2'b10);
        chk("R5", "needed cleared", refresh_needed, 2'b00);
        step(D);
        chk("R6", "inval chip1", row_invalidate, 8'b1010_1010);
        chk("R7", "no grant without pending", bank_grant, 0);
    endtask

    // R9
    task automatic t_err();
        do_reset();
        bank_pending = 8'b0000_0100;
        strobe(2'b01);
        bank_busy = 8'b0000_0001;
        step(P);
        chk("R9", "deferred", refresh_needed, 2'b01);
        step(P - 1);
        chk("R9", "no err yet", overrun_err, 0);
        step(1);
        chk("R9", "err set", overrun_err, 1);
        bank_busy = '0;
        step(1);
        chk("R9", "refresh starts", refresh_active, 2'b01);
        step(D);
        chk("R9", "err sticky", overrun_err, 1);
        chk("R7", "grant chip0 bank1", bank_grant, 8'b0000_0100);
    endtask

    // R10
    task automatic t_stagger();
        do_reset();
        strobe(2'b01);
        step(6);
        strobe(2'b10);
        step(P - 7);
        chk("R10", "chip0 only", refresh_active, 2'b01);
        step(6);
        chk("R10", "gap", refresh_active, 2'b00);
        step(1);
        chk("R10", "chip1 only", refresh_active, 2'b10);
    endtask

    initial begin
        step(1);
        t_reset();
        t_basic();
        t_defer();
        t_err();
        t_stagger();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule